// File: doc/BRIEF.md
# Byte-Wide Stored-Program Processor

This block is a small non-pipelined processor with an 8-bit datapath and a file of sixteen 8-bit registers. It drives one synchronous byte-wide memory port that serves both program and data over a 256-byte address space. It runs each instruction in a strict sequence. First it reads two instruction bytes. It then steps the program counter. Last it executes the instruction. A status output rises once the machine has stopped.

Every instruction is 16 bits long and has three fields. Bits 15:12 hold the operation code. Bits 11:8 hold a register number `r`. Bits 7:0 hold an operand. The operand is an 8-bit address or immediate, or it is a pair of source register numbers: `s` in bits 7:4 and `t` in bits 3:0. The host loads a program into memory, releases reset and waits for the halted output. It then reads the results back from memory.

Top module: `byte_machine`

## Requirements
- R1: While `rst_ni` is low, all registers are cleared, the program counter is 00, `halted_o` is low and no write strobe is driven. The first fetch after reset reads address 00.
- R2: The fetch reads the high instruction byte at PC and then the low byte at PC+1. PC then advances by 2 before execute, and all PC arithmetic wraps modulo 256 (after an instruction at FE the next fetch is at 00).
- R3: Opcode 1 (`1rAA`) loads the memory byte at address AA into register r.
- R4: Opcode 2 (`2rII`) loads the constant II into register r.
- R5: Opcode 3 (`3rAA`) writes register r to memory address AA. For example, `35A7` stores register 5 at A7.
- R6: Opcode 5 (`5rst`) writes s+t into r as a two's-complement sum, with the carry discarded (FF+02 gives 01).
- R7: Opcodes 7, 8 and 9 (`7rst`, `8rst`, `9rst`) write s OR t, s AND t and s XOR t into r.
- R8: Opcode C halts the machine. `halted_o` rises in the cycle after that instruction executes and stays high until reset. No memory write and no further instruction fetch occur while halted.
- R9: Any opcode other than 1, 2, 3, 5, 7, 8, 9 or C (that is 0, 4, 6, A, B, D, E, F) halts exactly like opcode C, and nothing later in the program executes.
- R10: The memory port never raises read and write in the same cycle. Read data is taken one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory address |
| mem_rd_o | output | 1 | Read strobe; data is returned on `mem_rdata_i` one cycle later |
| mem_wr_o | output | 1 | Write strobe for `mem_wdata_o` at `mem_addr_o` |
| mem_wdata_o | output | 8 | Write data (register r) |
| mem_rdata_i | input | 8 | Read data from the synchronous memory |
| halted_o | output | 1 | Machine has stopped |

## Verification
The assertions assume the memory behind the port is synchronous. They assume it returns the addressed byte on the edge after a read strobe and that it is not changed behind the processor's back while a program runs. The bench's memory model keeps to this. It holds the processor in reset whenever it loads a program or data, and it touches the memory only through a separate load path during that time. The programs are built from defined opcodes, except in the undefined-opcode tests. Those tests place the illegal word where the halt is expected, so the halted state is always reached.

// File: rtl/byte_machine_pkg.sv
package byte_machine_pkg;

  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int NREGS = 16;
  localparam int OPW   = 4;

  localparam logic [OPW-1:0] OPC_LDM = 4'h1;
  localparam logic [OPW-1:0] OPC_LDI = 4'h2;
  localparam logic [OPW-1:0] OPC_STM = 4'h3;
  localparam logic [OPW-1:0] OPC_ADD = 4'h5;
  localparam logic [OPW-1:0] OPC_OR  = 4'h7;
  localparam logic [OPW-1:0] OPC_AND = 4'h8;
  localparam logic [OPW-1:0] OPC_XOR = 4'h9;
  localparam logic [OPW-1:0] OPC_HLT = 4'hC;

  typedef enum logic [2:0] {
    ST_FHI, ST_FLO, ST_DEC, ST_EXE, ST_LWB, ST_HLT
  } seq_st_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_OR, ALU_AND, ALU_XOR} alu_op_e;

  typedef enum logic [1:0] {WB_ALU, WB_IMM, WB_MEM} wb_sel_e;

  // opcodes that continue execution (halt excluded)
  function automatic logic op_runs(logic [OPW-1:0] op);
    return (op == OPC_LDM) || (op == OPC_LDI) || (op == OPC_STM) ||
           (op == OPC_ADD) || (op == OPC_OR)  || (op == OPC_AND) ||
           (op == OPC_XOR);
  endfunction

  function automatic logic op_alu(logic [OPW-1:0] op);
    return (op == OPC_ADD) || (op == OPC_OR) || (op == OPC_AND) || (op == OPC_XOR);
  endfunction

endpackage

// File: rtl/bm_regfile.sv
module bm_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 16,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [RAW-1:0] ra_i,
  input  logic [RAW-1:0] rb_i,
  input  logic [RAW-1:0] rc_i,
  output logic [DW-1:0]  da_o,
  output logic [DW-1:0]  db_o,
  output logic [DW-1:0]  dc_o
);

  logic [DW-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && (waddr_i == RAW'(g)))     regs_q[g] <= wdata_i;
    end
  end

  assign da_o = regs_q[ra_i];
  assign db_o = regs_q[rb_i];
  assign dc_o = regs_q[rc_i];

endmodule

// File: rtl/bm_alu.sv
module bm_alu
  import byte_machine_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;  // carry dropped
      ALU_OR:  y_o = a_i | b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/bm_sequencer.sv
module bm_sequencer
  import byte_machine_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int RAW = 4,
  localparam int IW = 2 * DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic [RAW-1:0] rd_o,
  output logic [RAW-1:0] rs_o,
  output logic [RAW-1:0] rt_o,
  output logic [AW-1:0]  imm_o,
  output logic           rf_we_o,
  output wb_sel_e        wb_sel_o,
  output alu_op_e        alu_op_o,
  output logic           halted_o
);

  seq_st_e          st_q, st_d;
  logic [AW-1:0]    pc_q;
  logic [IW-1:0]    ir_q;
  logic [OPW-1:0]   opc;

  assign opc   = ir_q[IW-1 -: OPW];
  assign rd_o  = ir_q[IW-OPW-1 -: RAW];
  assign imm_o = ir_q[AW-1:0];
  assign rs_o  = imm_o[2*RAW-1:RAW];
  assign rt_o  = imm_o[RAW-1:0];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FHI: st_d = ST_FLO;
      ST_FLO: st_d = ST_DEC;
      ST_DEC: st_d = ST_EXE;
      ST_EXE: begin
        if (opc == OPC_LDM)   st_d = ST_LWB;
        else if (op_runs(opc)) st_d = ST_FHI;
        else                   st_d = ST_HLT;  // halt and every undefined code
      end
      ST_LWB: st_d = ST_FHI;
      default: st_d = ST_HLT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_FHI;
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_FLO) ir_q[IW-1:DW] <= mem_rdata_i;
      if (st_q == ST_DEC) begin
        ir_q[DW-1:0] <= mem_rdata_i;
        pc_q         <= pc_q + AW'(2);
      end
    end
  end

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_wr_o   = 1'b0;
    mem_addr_o = imm_o;
    unique case (st_q)
      ST_FHI: begin mem_rd_o = 1'b1; mem_addr_o = pc_q;          end
      ST_FLO: begin mem_rd_o = 1'b1; mem_addr_o = pc_q + AW'(1); end
      ST_EXE: begin
        mem_rd_o = (opc == OPC_LDM);
        mem_wr_o = (opc == OPC_STM);
      end
      default: ;
    endcase
  end

  assign rf_we_o  = ((st_q == ST_EXE) && ((opc == OPC_LDI) || op_alu(opc))) ||
                    (st_q == ST_LWB);
  assign wb_sel_o = (st_q == ST_LWB) ? WB_MEM : (opc == OPC_LDI) ? WB_IMM : WB_ALU;

  always_comb begin
    unique case (opc)
      OPC_OR:  alu_op_o = ALU_OR;
      OPC_AND: alu_op_o = ALU_AND;
      OPC_XOR: alu_op_o = ALU_XOR;
      default: alu_op_o = ALU_ADD;
    endcase
  end

  assign halted_o = (st_q == ST_HLT);

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEC) |=> (pc_q == $past(pc_q) + AW'(2)));

  a_r2_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_DEC) |=> $stable(pc_q));

  a_r3_load_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && (st_q == ST_EXE)) |=> (rf_we_o && (wb_sel_o == WB_MEM)));

  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  a_r8_quiet_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_wr_o && !mem_rd_o && !rf_we_o));

  a_r9_undef_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_EXE) && !op_runs(opc)) |=> halted_o);

  a_r10_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

endmodule

// File: rtl/byte_machine.sv
module byte_machine
  import byte_machine_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          halted_o
);

  localparam int RAW = $clog2(NREGS);

  logic [RAW-1:0] rd, rs, rt;
  logic [AW-1:0]  imm;
  logic           rf_we;
  wb_sel_e        wb_sel;
  alu_op_e        alu_op;
  logic [DW-1:0]  d_s, d_t, d_r, alu_y, wdata;

  bm_sequencer #(.DW(DW), .AW(AW), .RAW(RAW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_rdata_i(mem_rdata_i),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .rd_o       (rd),
    .rs_o       (rs),
    .rt_o       (rt),
    .imm_o      (imm),
    .rf_we_o    (rf_we),
    .wb_sel_o   (wb_sel),
    .alu_op_o   (alu_op),
    .halted_o   (halted_o)
  );

  bm_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .waddr_i(rd),
    .wdata_i(wdata),
    .ra_i   (rs),
    .rb_i   (rt),
    .rc_i   (rd),
    .da_o   (d_s),
    .db_o   (d_t),
    .dc_o   (d_r)
  );

  bm_alu #(.DW(DW)) u_alu (
    .op_i(alu_op),
    .a_i (d_s),
    .b_i (d_t),
    .y_o (alu_y)
  );

  always_comb begin
    unique case (wb_sel)
      WB_IMM:  wdata = DW'(imm);
      WB_MEM:  wdata = mem_rdata_i;
      default: wdata = alu_y;
    endcase
  end

  assign mem_wdata_o = d_r;

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!halted_o && !mem_wr_o));

endmodule

// File: tb/byte_machine_bench.sv
`timescale 1ns/1ps
module byte_machine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, rdata_q;
  logic       mem_rd, mem_wr, halted;

  always #2 clk = ~clk;

  byte_machine u_byte_machine (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mem_addr_o (mem_addr),
    .mem_rd_o   (mem_rd),
    .mem_wr_o   (mem_wr),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata_q),
    .halted_o   (halted)
  );

  logic [7:0] mem [256];
  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  int         wr_halted_cnt = 0, overlap_cnt = 0;

  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) rdata_q <= mem[mem_addr];
    if (rst_n && halted && mem_wr) wr_halted_cnt++;
    if (rst_n && mem_rd && mem_wr) overlap_cnt++;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
  endtask

  task automatic poke_w(input logic [7:0] a, input logic [15:0] w);
    poke(a, w[15:8]);
    poke(a + 8'd1, w[7:0]);
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    ld_en = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run_halt();
    for (int c = 0; c < 4000 && !halted; c++) @(negedge clk);
  endtask

  // {opcode, a, b, expected}
  localparam logic [27:0] VEC [8] = '{
    {4'h5, 8'h03, 8'h04, 8'h07},
    {4'h5, 8'hFF, 8'h02, 8'h01},
    {4'h7, 8'h55, 8'h0F, 8'h5F},
    {4'h8, 8'h55, 8'h0F, 8'h05},
    {4'h9, 8'h55, 8'h0F, 8'h5A},
    {4'h8, 8'hF0, 8'h3C, 8'h30},
    {4'h7, 8'h00, 8'h00, 8'h00},
    {4'h9, 8'hFF, 8'hFF, 8'h00}
  };

  localparam logic [3:0] UNDEF [8] = '{4'h0, 4'h4, 4'h6, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 199000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) poke(8'(i), 8'h00);
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 write strobe in reset", int'(mem_wr), 0);
    chk("R1 PC=00 in reset", int'(mem_addr), 8'h00);

    // table: R4 immediate loads, R6 add, R7 logic ops, R5 store
    for (int i = 0; i < 8; i++) begin
      logic [27:0] v;
      v = VEC[i];
      hold_reset();
      poke_w(8'h00, {4'h2, 4'h1, v[23:16]});
      poke_w(8'h02, {4'h2, 4'h2, v[15:8]});
      poke_w(8'h04, {v[27:24], 4'h3, 8'h12});
      poke_w(8'h06, 16'h33F0);
      poke_w(8'h08, 16'hC000);
      poke(8'hF0, 8'hEE);
      release_reset();
      run_halt();
      chk((v[27:24] == 4'h5) ? "R4 R6 add result" : "R4 R7 logic result",
          int'(mem[8'hF0]), int'(v[7:0]));
    end

    // R3 R6 R5: two memory operands summed and stored
    hold_reset();
    poke_w(8'h00, 16'h156C);
    poke_w(8'h02, 16'h166D);
    poke_w(8'h04, 16'h5056);
    poke_w(8'h06, 16'h306E);
    poke_w(8'h08, 16'hC000);
    poke(8'h6C, 8'h17);
    poke(8'h6D, 8'h25);
    poke(8'h6E, 8'h00);
    release_reset();
    run_halt();
    chk("R3 R6 memory sum", int'(mem[8'h6E]), 8'h3C);
    chk("R8 halted after program", int'(halted), 1);

    // R5: 35A7 stores register 5 at A7
    hold_reset();
    poke_w(8'h00, 16'h255B);
    poke_w(8'h02, 16'h35A7);
    poke_w(8'h04, 16'hC000);
    poke(8'hA7, 8'h00);
    release_reset();
    run_halt();
    chk("R5 store 35A7", int'(mem[8'hA7]), 8'h5B);

    // R1: register 5 holds 5B from the last run; reset must clear it
    hold_reset();
    poke_w(8'h00, 16'h3580);
    poke_w(8'h02, 16'hC000);
    poke(8'h80, 8'hFF);
    release_reset();
    run_halt();
    chk("R1 registers cleared", int'(mem[8'h80]), 8'h00);

    // R8: halt timing, stickiness, no later store
    hold_reset();
    poke_w(8'h00, 16'hC000);
    poke_w(8'h02, 16'h31F1);
    poke(8'hF1, 8'h5A);
    release_reset();
    repeat (3) @(negedge clk);
    chk("R8 not halted during execute", int'(halted), 0);
    @(negedge clk);
    chk("R8 halted cycle after execute", int'(halted), 1);
    repeat (20) @(negedge clk);
    chk("R8 halt sticky", int'(halted), 1);
    chk("R8 no store after halt", int'(mem[8'hF1]), 8'h5A);

    // R9: every undefined opcode halts
    for (int i = 0; i < 8; i++) begin
      hold_reset();
      poke_w(8'h00, 16'h2111);
      poke_w(8'h02, {UNDEF[i], 12'h123});
      poke_w(8'h04, 16'h31F2);
      poke_w(8'h06, 16'hC000);
      poke(8'hF2, 8'h5A);
      release_reset();
      run_halt();
      chk("R9 undefined opcode halts", int'(halted), 1);
      chk("R9 nothing after undefined opcode", int'(mem[8'hF2]), 8'h5A);
    end

    // R2: PC wraps from FE to 00
    hold_reset();
    for (int i = 0; i < 256; i += 2) poke_w(8'(i), 16'h2000);
    release_reset();
    for (int c = 0; c < 2000 && !(mem_rd && mem_addr == 8'hFF); c++) @(negedge clk);
    chk("R2 low byte fetched at FF", int'(mem_addr), 8'hFF);
    repeat (3) @(negedge clk);
    chk("R2 fetch wraps to 00", int'({mem_rd, mem_addr}), 9'h100);

    chk("R8 writes while halted", wr_halted_cnt, 0);
    chk("R10 read and write together", overlap_cnt, 0);

    summary();
    $finish;
  end

endmodule